// File: doc/BRIEF.md
# Transmit Jabber Guard

This block sits in the transmit enable path of a 10 Mb/s twisted-pair transmitter. It stops a faulty transmitter from holding the line for too long. On each bit-rate tick it counts the bit times during which the transmit request stays high without a break. Before the limit is reached, the gated enable follows the request in the same cycle. When the request is still high on the tick after the limit, the guard trips. It then forces the gated enable low for a fixed lockout, which is 0.525 s or 5,250,000 bit times at the default parameters. During the lockout it raises a status flag.

The control is a four-state machine:
- **IDLE**: the request is low.
- **ACTIVE**: a transmission is running and being counted.
- **LOCKOUT**: the output is forced idle.
- **REARM**: the lockout has ended, but the request has not yet been seen low.

The transitions are:
- **start**: IDLE to ACTIVE when the request rises.
- **stop**: ACTIVE to IDLE when the request falls.
- **trip**: ACTIVE to LOCKOUT when the limit is overrun.
- **expire**: LOCKOUT to REARM when the last lockout tick is counted.
- **release**: REARM to IDLE when the request is low.
- **bypass**: any state to IDLE while the inhibit input is high.

One counter serves both the transmission count and the lockout count. The counter clears on every transition that changes which of the two it is measuring.

Top module: `tx_jabber_guard`

## Requirements
- R1: After reset the state is IDLE. With the request low, the gated enable and the jabber flag are both 0.
- R2: Outside lockout and rearm, the gated enable equals the transmit request in the same cycle. A request held high for up to LIMIT_BITS ticks is passed unchanged.
- R3: If the request is still high on tick number LIMIT_BITS+1 of an unbroken transmission, the gated enable is 0 and the flag is 1 from the next clock onward.
- R4: Any cycle in which the request is low clears the bit-time count. Bursts of LIMIT_BITS ticks that are separated by at least one low cycle never trip the guard.
- R5: The lockout lasts exactly LOCK_BITS ticks, counted from the cycle after the trip. The flag falls in the clock after the last of those ticks.
- R6: During lockout the request is ignored. Toggling it changes neither the gated enable (held at 0) nor the length of the lockout.
- R7: After the lockout, the gated enable stays 0 while the request remains high. Once the request has been sampled low, the next high request passes.
- R8: While the inhibit input is 1, the gated enable equals the request and the flag is 0, however long the transmission runs.
- R9: Raising inhibit during lockout drops the flag in the same cycle and returns the state to IDLE at the next clock, with the count cleared. When inhibit is released, a fresh transmission is allowed a full LIMIT_BITS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_req | input | 1 | Transmit request from the MAC side |
| jab_inhibit | input | 1 | 1 bypasses the guard entirely |
| tx_en_out | output | 1 | Gated transmit enable to the line side |
| jab_flag | output | 1 | 1 while the lockout is in force |

## Verification
The bench builds the guard with LIMIT_BITS = 20 and LOCK_BITS = 30 instead of 50,000 and 5,250,000. This brings a trip and a complete lockout within a few dozen cycles. It can therefore check the exact tick on which the output is cut and the exact cycle in which the flag falls. The same small values let the bench run several trips per test, including one cancelled by the inhibit input and one followed by a rearm wait.

// File: rtl/jg_pkg.sv
package jg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_LOCKOUT = 2'd2,
        ST_REARM   = 2'd3
    } jg_state_e;
endpackage

// File: rtl/jg_counter.sv
module jg_counter #(
    parameter int CW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/jg_ctrl.sv
module jg_ctrl
    import jg_pkg::*;
#(
    parameter int LIMIT_BITS = 50000,
    parameter int LOCK_BITS  = 5250000,
    parameter int CW         = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          tx_req,
    input  logic          jab_inhibit,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          tx_en_out,
    output logic          jab_flag
);
    localparam logic [CW-1:0] LIM_V  = CW'(LIMIT_BITS);
    localparam logic [CW-1:0] LAST_V = CW'(LOCK_BITS - 1);

    jg_state_e state_q, state_d;
    logic      trip, lock_done;

    assign trip      = bit_tick && tx_req && (cnt == LIM_V);
    assign lock_done = bit_tick && (cnt == LAST_V);

    // next-state and counter control
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: begin
                if (!tx_req) begin
                    state_d = ST_IDLE;
                    cnt_clr = 1'b1;
                end else if (trip) begin
                    state_d = ST_LOCKOUT;
                    cnt_clr = 1'b1;
                end else begin
                    state_d = ST_ACTIVE;
                    cnt_inc = bit_tick;
                end
            end
            ST_LOCKOUT: begin
                cnt_inc = bit_tick;
                if (lock_done) begin
                    state_d = ST_REARM;
                    cnt_clr = 1'b1;
                end
            end
            ST_REARM: begin
                cnt_clr = 1'b1;
                if (!tx_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (jab_inhibit) begin
            state_d = ST_IDLE;
            cnt_clr = 1'b1;
            cnt_inc = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        if (jab_inhibit) begin
            tx_en_out = tx_req;
            jab_flag  = 1'b0;
        end else begin
            tx_en_out = tx_req && (state_q == ST_IDLE || state_q == ST_ACTIVE);
            jab_flag  = (state_q == ST_LOCKOUT);
        end
    end

    // R3: an enabled output never coexists with an overrun count
    p_out_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_out && !jab_inhibit) |-> (cnt <= LIM_V));

    // R3: the flag only rises after a transmission was being requested
    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jab_flag) |-> $past(tx_req));

    // R4: a low request empties the count by the next cycle
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!jab_inhibit && !tx_req && (state_q == ST_IDLE || state_q == ST_ACTIVE))
        |=> (cnt == '0));

    // R7: a request held high after lockout stays blocked
    p_rearm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REARM && tx_req && !jab_inhibit)
        |=> (!tx_en_out || jab_inhibit));

    // R9: inhibit always returns the machine to IDLE
    p_inh_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        jab_inhibit |=> (state_q == ST_IDLE));
endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
    parameter int LIMIT_BITS = 50000,
    parameter int LOCK_BITS  = 5250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic jab_inhibit,
    output logic tx_en_out,
    output logic jab_flag
);
    localparam int SPAN = (LIMIT_BITS > LOCK_BITS) ? LIMIT_BITS : LOCK_BITS;
    localparam int CW   = $clog2(SPAN + 1);

    logic [CW-1:0] cnt;
    logic          cnt_clr, cnt_inc;

    jg_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    jg_ctrl #(
        .LIMIT_BITS (LIMIT_BITS),
        .LOCK_BITS  (LOCK_BITS),
        .CW         (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .tx_req      (tx_req),
        .jab_inhibit (jab_inhibit),
        .cnt         (cnt),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .tx_en_out   (tx_en_out),
        .jab_flag    (jab_flag)
    );
endmodule

// File: tb/test_tx_jabber_guard.sv
module test_tx_jabber_guard;
    localparam int LIM  = 20;
    localparam int LOCK = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic tx_req = 1'b0;
    logic jab_inhibit = 1'b0;
    logic tx_en_out, jab_flag;
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    tx_jabber_guard #(.LIMIT_BITS(LIM), .LOCK_BITS(LOCK)) i_tx_jabber_guard (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_req(tx_req),
        .jab_inhibit(jab_inhibit), .tx_en_out(tx_en_out), .jab_flag(jab_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, settle, then outputs may be sampled
    task automatic drv(input logic rq, input logic tk, input logic inh);
        @(negedge clk);
        tx_req = rq; bit_tick = tk; jab_inhibit = inh;
        #1;
    endtask

    task automatic trip_guard();
        for (int i = 0; i < LIM; i++) begin
            drv(1, 1, 0);
            chk("R2 out within limit", tx_en_out, 1'b1);
        end
        drv(1, 1, 0);
        chk("R3 out on tripping tick", tx_en_out, 1'b1);
        drv(1, 0, 0);
        chk("R3 out cut after trip", tx_en_out, 1'b0);
        chk("R3 flag after trip", jab_flag, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) drv(0, 0, 0);
        rst_n = 1'b1;
        drv(0, 0, 0);
        chk("R1 out after reset", tx_en_out, 1'b0);
        chk("R1 flag after reset", jab_flag, 1'b0);
        drv(1, 0, 0);
        chk("R2 out follows request", tx_en_out, 1'b1);
        drv(0, 0, 0);
        chk("R2 out follows low request", tx_en_out, 1'b0);
    endtask

    task automatic t_lockout();
        trip_guard();
        for (int i = 0; i < LOCK - 1; i++) begin
            drv(logic'(i % 2), 1, 0);
            chk("R6 out held low in lockout", tx_en_out, 1'b0);
            chk("R5 flag held in lockout", jab_flag, 1'b1);
        end
        drv(1, 1, 0);
        chk("R5 flag on last lockout tick", jab_flag, 1'b1);
        drv(1, 0, 0);
        chk("R5 flag falls after lockout", jab_flag, 1'b0);
        chk("R7 out low in rearm", tx_en_out, 1'b0);
        repeat (3) begin
            drv(1, 1, 0);
            chk("R7 out held while request high", tx_en_out, 1'b0);
        end
        drv(0, 0, 0);
        chk("R7 out low on release", tx_en_out, 1'b0);
        drv(1, 0, 0);
        chk("R7 new request passes", tx_en_out, 1'b1);
        drv(0, 0, 0);
    endtask

    task automatic t_gaps();
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < LIM; i++) begin
                drv(1, 1, 0);
                drv(1, 0, 0);
            end
            chk("R4 burst at limit passes", tx_en_out, 1'b1);
            chk("R4 no flag", jab_flag, 1'b0);
            drv(0, 0, 0);
        end
        drv(1, 1, 0);
        chk("R4 burst after gap passes", tx_en_out, 1'b1);
        drv(0, 0, 0);
    endtask

    task automatic t_inhibit();
        for (int i = 0; i < 3 * LIM; i++) begin
            drv(1, 1, 1);
            if (i % 10 == 9) begin
                chk("R8 pass-through under inhibit", tx_en_out, 1'b1);
                chk("R8 no flag under inhibit", jab_flag, 1'b0);
            end
        end
        drv(0, 1, 1);
        chk("R8 low request under inhibit", tx_en_out, 1'b0);
        drv(0, 0, 0);
    endtask

    task automatic t_cancel();
        trip_guard();
        repeat (5) drv(1, 1, 0);
        chk("R9 still locked before inhibit", jab_flag, 1'b1);
        drv(1, 0, 1);
        chk("R9 flag drops with inhibit", jab_flag, 1'b0);
        chk("R9 out passes with inhibit", tx_en_out, 1'b1);
        drv(1, 0, 0);
        chk("R9 out after inhibit released", tx_en_out, 1'b1);
        for (int i = 0; i < LIM; i++) drv(1, 1, 0);
        chk("R9 fresh count allows full limit", tx_en_out, 1'b1);
        chk("R9 no flag in fresh run", jab_flag, 1'b0);
        drv(0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_lockout();
        t_gaps();
        t_inhibit();
        t_cancel();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule